// File: doc/BRIEF.md
# Reset-Hold Duration Counter

This block measures how long an external active-low reset line is held asserted. Software can then tell a short press of a reset button from a long one, such as a request to restore factory settings. It runs from a reference clock in an always-on domain. At the nominal 25 MHz each count is 40 ns, so 25,000,000 counts make one second. With the default 29-bit width the counter covers about 21.4 seconds.

The line passes through a synchronizer and then enables a saturating counter. The count is kept after the line is released. If the line is asserted again, counting continues from the kept value. The count only returns to zero when software writes the clear bit.

The block has a single register. A read returns the count zero-extended. A write with the clear bit set zeroes the count on the next clock.

Top module: `reset_hold_counter`

## Requirements
- R1: While the synchronized hold line is low and no clear is written, the count rises by exactly one on each clock edge.
- R2: The hold input is synchronized through SYNC_STAGES flops (default 2). With the default, the first increment occurs on the third rising edge after the line falls, and the final count equals the number of rising edges during which the line was low.
- R3: The count is CNT_W bits wide (default 29). It stops at the all-ones value (2^CNT_W-1) and never wraps.
- R4: A read returns the count in rd_data_o[CNT_W-1:0]. All higher bits read as zero.
- R5: A write with wr_data_i bit CLR_BIT (default 31) set zeroes the count on the next clock edge. This takes priority over an increment in that same cycle.
- R6: When the hold line is high, the count keeps its value. A later assertion resumes counting from that value.
- R7: A write with bit CLR_BIT clear leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| hold_ni | input | 1 | Asynchronous active-low reset line being timed |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Register write data; bit CLR_BIT clears the count |
| rd_data_o | output | REG_W | Register read data; count zero-extended |

## Verification
The bench builds the block with CNT_W set to 6, so the counter saturates at 63 after only a few dozen held cycles. This brings the saturation boundary within a short run. The synchronizer depth and the position of the clear bit keep their default values of 2 and 31. As a result, the three-edge latency, the clear priority and the zero high bits of the read are all checked as shipped.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  localparam int unsigned DEF_CNT_W   = 29;
  localparam int unsigned DEF_REG_W   = 32;
  localparam int unsigned DEF_CLR_BIT = 31;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/rhc_sync.sv
module rhc_sync #(
  parameter int unsigned STAGES = rhc_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  // Stages reset to 1: the timed line reads as released.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b1;
    else         stage_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b1;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rhc_counter.sv
module rhc_counter #(
  parameter int unsigned CNT_W = rhc_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            count_q <= '0;
    else if (clear_i)                       count_q <= '0;
    else if (active_i && count_q != CNT_MAX) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !clear_i && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_MAX && !clear_i) |=> (count_q == CNT_MAX));

  assert_clear_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_q == '0));

  assert_hold_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !clear_i) |=> $stable(count_q));
endmodule

// File: rtl/rhc_regif.sv
module rhc_regif #(
  parameter int unsigned CNT_W   = rhc_pkg::DEF_CNT_W,
  parameter int unsigned REG_W   = rhc_pkg::DEF_REG_W,
  parameter int unsigned CLR_BIT = rhc_pkg::DEF_CLR_BIT
) (
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             clear_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = REG_W - CNT_W;

  assign clear_o = wr_en_i && wr_data_i[CLR_BIT];

  if (PAD_W > 0) begin : g_pad
    assign rd_data_o = {{PAD_W{1'b0}}, count_i};
  end else begin : g_nopad
    assign rd_data_o = count_i;
  end
endmodule

// File: rtl/reset_hold_counter.sv
module reset_hold_counter #(
  parameter int unsigned CNT_W       = rhc_pkg::DEF_CNT_W,
  parameter int unsigned REG_W       = rhc_pkg::DEF_REG_W,
  parameter int unsigned CLR_BIT     = rhc_pkg::DEF_CLR_BIT,
  parameter int unsigned SYNC_STAGES = rhc_pkg::DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic             hold_sync_n;
  logic             clear;
  logic [CNT_W-1:0] count;

  rhc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (hold_ni),
    .sync_o  (hold_sync_n)
  );

  rhc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (!hold_sync_n),
    .clear_i  (clear),
    .count_o  (count)
  );

  rhc_regif #(.CNT_W(CNT_W), .REG_W(REG_W), .CLR_BIT(CLR_BIT)) i_regif (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_i   (count),
    .clear_o   (clear),
    .rd_data_o (rd_data_o)
  );

  // R2: the count cannot move in the cycle right after the raw line first falls.
  assert_sync_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_ni) && !wr_en_i) |=> $stable(rd_data_o));
endmodule

// File: tb/test_reset_hold_counter.sv
module test_reset_hold_counter;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned REG_W = 32;
  localparam logic [REG_W-1:0] MAXV = (1 << CNT_W) - 1;
  localparam logic [REG_W-1:0] CLR  = 32'h8000_0000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hold_n = 1'b1;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reset_hold_counter #(.CNT_W(CNT_W), .REG_W(REG_W)) i_reset_hold_counter (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .hold_ni   (hold_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

  task automatic check(input string req, input logic [REG_W-1:0] exp);
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s: rd_data=%0h expected=%0h", req, rd_data, exp);
    end
  endtask

  task automatic reg_write(input logic [REG_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // Hold the line low for n rising edges, then let the synchronizer drain.
  task automatic press(input int n);
    @(negedge clk); hold_n = 1'b0;
    repeat (n) @(negedge clk);
    hold_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    check("reset", '0);
  endtask

  task automatic t_latency_step;
    reg_write(CLR);
    @(negedge clk); hold_n = 1'b0;
    @(negedge clk); check("R2 edge1", 0);
    @(negedge clk); check("R2 edge2", 0);
    @(negedge clk); check("R2 edge3", 1);
    @(negedge clk); check("R1 step", 2);
    @(negedge clk); check("R1 step", 3);
    hold_n = 1'b1;
    repeat (2) @(negedge clk); check("R2 total", 5);
  endtask

  task automatic t_hold_resume;
    reg_write(CLR);
    press(7); check("R6 held", 7);
    repeat (10) @(negedge clk); check("R6 stable", 7);
    press(4); check("R6 resume", 11);
  endtask

  task automatic t_no_clear;
    reg_write(32'h7FFF_FFFF); check("R7 bit31 clear", 11);
    reg_write(CLR); check("R5 clear", 0);
  endtask

  task automatic t_clear_during_hold;
    @(negedge clk); hold_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_en = 1'b1; wr_data = CLR;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R5 priority", 0);
    @(negedge clk); check("R5 resume", 1);
    hold_n = 1'b1;
    repeat (2) @(negedge clk); check("R5 after", 3);
  endtask

  task automatic t_saturate;
    reg_write(CLR);
    press(70); check("R3 saturate", MAXV);
    check("R4 upper zero", MAXV & ((1 << CNT_W) - 1));
    press(5); check("R3 no wrap", MAXV);
    reg_write(CLR); check("R3 clear from max", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_latency_step;
    t_hold_resume;
    t_no_clear;
    t_clear_during_hold;
    t_saturate;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule